// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit works out the operand address and the following program counter for an 8-bit processor with a 16-bit, 64 KB address space. The opcode has already been decoded. A separate sequencer supplies the addressing mode, the one or two operand bytes that follow the opcode, both index registers, the start address of the instruction and a flag for an extra opcode byte. For branches it also supplies whether the branch condition holds.

The arithmetic is combinational. A strobe captures the results in an output register, so they appear one clock after the strobe and stay there until the next strobe. The mode is coded on two bits: 00 inherent, 01 extended, 10 indexed, 11 relative. The index select bit picks IX when 0 and IY when 1. In relative mode the address output carries the branch target.

Top module: `ea_gen_unit`

## Requirements
- R1: In extended mode (mode 01) the address output equals {op_first, op_second}, with the first operand byte as the high byte, and addr_ok is 1.
- R2: In indexed mode (mode 10) the address output equals the selected index register plus the zero-extended first operand byte, and addr_ok is 1. idx_sel 0 selects IX and idx_sel 1 selects IY.
- R3: All 16-bit sums wrap modulo 65536: the indexed address, the next program counter and the branch target.
- R4: In inherent mode (mode 00) addr_ok is 0 and the address output is 0000h.
- R5: In relative mode (mode 11) with br_taken set, the target and next_pc both equal the instruction start plus the length plus the sign-extended first operand byte, and addr_ok is 1.
- R6: In relative mode with br_taken clear, next_pc equals the instruction start plus the length, and the address output still shows the target.
- R7: The instruction length is 1 for inherent, 2 for indexed, 2 for relative and 3 for extended, plus 1 in every mode when has_pre is set.
- R8: For inherent, extended and indexed modes, next_pc equals the instruction start plus the length.
- R9: Outputs change only on the clock edge where strobe is high, one clock after the inputs are presented. Without a strobe they hold their values.
- R10: A synchronous active-high reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe | input | 1 | Captures the computed results on this edge |
| mode | input | 2 | Addressing mode: 00 inherent, 01 extended, 10 indexed, 11 relative |
| op_first | input | 8 | First operand byte after the opcode |
| op_second | input | 8 | Second operand byte after the opcode |
| idx_sel | input | 1 | Index register select: 0 selects IX, 1 selects IY |
| reg_ix | input | 16 | Index register X |
| reg_iy | input | 16 | Index register Y |
| insn_pc | input | 16 | Start address of the instruction |
| br_taken | input | 1 | Branch condition holds |
| has_pre | input | 1 | An extra opcode byte is present |
| addr_out | output | 16 | Effective address, or the branch target in relative mode |
| addr_ok | output | 1 | Set when the address output is an operand address |
| len_out | output | 3 | Instruction length in bytes |
| next_pc | output | 16 | Address of the next instruction to execute |

## Verification
The assertions assume that the inputs are stable and known on the edge where strobe is high. The relations they check compare each output with the inputs sampled one edge earlier. The bench drives every input on the falling edge and holds it through the next rising edge, so each strobe sees one complete input set. The bench samples the registered outputs at the falling edge after the capture. The hold check changes the inputs while strobe is low, so a missing strobe gate shows at the outputs.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;
    localparam int AW    = 16;
    localparam int DW    = 8;
    localparam int LEN_W = 3;

    typedef enum logic [1:0] {
        AM_INH = 2'b00,
        AM_EXT = 2'b01,
        AM_IDX = 2'b10,
        AM_REL = 2'b11
    } am_e;

    typedef struct packed {
        logic [AW-1:0]    addr;
        logic             ok;
        logic [LEN_W-1:0] len;
        logic [AW-1:0]    npc;
    } ea_res_t;

    function automatic logic [LEN_W-1:0] base_len(am_e m);
        case (m)
            AM_INH:  return LEN_W'(1);
            AM_EXT:  return LEN_W'(3);
            default: return LEN_W'(2);
        endcase
    endfunction

    function automatic logic [AW-1:0] sext8(logic [DW-1:0] b);
        return {{(AW-DW){b[DW-1]}}, b};
    endfunction
endpackage

// File: rtl/ea_len_calc.sv
module ea_len_calc
    import ea_gen_pkg::*;
(
    input  am_e              mode,
    input  logic             has_pre,
    output logic [LEN_W-1:0] len
);
    always_comb begin
        len = base_len(mode) + LEN_W'(has_pre);
    end
endmodule

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
    import ea_gen_pkg::*;
#(
    parameter int NUM_IDX = 2
) (
    input  am_e                  mode,
    input  logic [DW-1:0]        op_first,
    input  logic [DW-1:0]        op_second,
    input  logic                 idx_sel,
    input  logic [NUM_IDX*AW-1:0] idx_regs,
    input  logic [AW-1:0]        seq_pc,
    output logic [AW-1:0]        addr,
    output logic                 ok
);
    localparam int SEL_W = (NUM_IDX > 1) ? $clog2(NUM_IDX) : 1;

    logic [AW-1:0] idx_arr [NUM_IDX];

    for (genvar g = 0; g < NUM_IDX; g++) begin : g_idx
        assign idx_arr[g] = idx_regs[g*AW +: AW];
    end

    logic [AW-1:0] idx_base;
    always_comb begin
        idx_base = idx_arr[SEL_W'(idx_sel)];
    end

    always_comb begin
        addr = '0;
        ok   = 1'b1;
        case (mode)
            AM_EXT: addr = {op_first, op_second};
            AM_IDX: addr = idx_base + {{(AW-DW){1'b0}}, op_first};
            AM_REL: addr = seq_pc + sext8(op_first);
            default: begin
                addr = '0;
                ok   = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/ea_pc_calc.sv
module ea_pc_calc
    import ea_gen_pkg::*;
(
    input  am_e           mode,
    input  logic          br_taken,
    input  logic [AW-1:0] seq_pc,
    input  logic [AW-1:0] target,
    output logic [AW-1:0] npc
);
    always_comb begin
        npc = (mode == AM_REL && br_taken) ? target : seq_pc;
    end
endmodule

// File: rtl/ea_gen_unit.sv
module ea_gen_unit
    import ea_gen_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        strobe,
    input  logic [1:0]  mode,
    input  logic [7:0]  op_first,
    input  logic [7:0]  op_second,
    input  logic        idx_sel,
    input  logic [15:0] reg_ix,
    input  logic [15:0] reg_iy,
    input  logic [15:0] insn_pc,
    input  logic        br_taken,
    input  logic        has_pre,
    output logic [15:0] addr_out,
    output logic        addr_ok,
    output logic [2:0]  len_out,
    output logic [15:0] next_pc
);
    am_e              am;
    logic [LEN_W-1:0] len_c;
    logic [AW-1:0]    seq_pc;
    ea_res_t          res_c;
    ea_res_t          res_q;

    assign am = am_e'(mode);

    ea_len_calc u_len (
        .mode    (am),
        .has_pre (has_pre),
        .len     (len_c)
    );

    assign seq_pc = insn_pc + {{(AW-LEN_W){1'b0}}, len_c};

    ea_addr_calc #(.NUM_IDX(2)) u_addr (
        .mode      (am),
        .op_first  (op_first),
        .op_second (op_second),
        .idx_sel   (idx_sel),
        .idx_regs  ({reg_iy, reg_ix}),
        .seq_pc    (seq_pc),
        .addr      (res_c.addr),
        .ok        (res_c.ok)
    );

    ea_pc_calc u_pc (
        .mode     (am),
        .br_taken (br_taken),
        .seq_pc   (seq_pc),
        .target   (res_c.addr),
        .npc      (res_c.npc)
    );

    assign res_c.len = len_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else if (strobe) begin
            res_q <= res_c;
        end
    end

    assign addr_out = res_q.addr;
    assign addr_ok  = res_q.ok;
    assign len_out  = res_q.len;
    assign next_pc  = res_q.npc;

    // R1
    a_r1_ext_addr: assert property (@(posedge clk) disable iff (rst)
        (strobe && mode == 2'b01) |=> (addr_out == {$past(op_first), $past(op_second)} && addr_ok));

    // R2
    a_r2_idx_addr: assert property (@(posedge clk) disable iff (rst)
        (strobe && mode == 2'b10) |=>
        (addr_out == (($past(idx_sel) ? $past(reg_iy) : $past(reg_ix)) + {8'h00, $past(op_first)})));

    // R4
    a_r4_inh_noaddr: assert property (@(posedge clk) disable iff (rst)
        (strobe && mode == 2'b00) |=> (!addr_ok && addr_out == 16'h0000));

    // R6
    a_r6_rel_fallthru: assert property (@(posedge clk) disable iff (rst)
        (strobe && mode == 2'b11 && !br_taken) |=>
        (next_pc == $past(insn_pc) + 16'd2 + {15'd0, $past(has_pre)}));

    // R7
    a_r7_len_range: assert property (@(posedge clk) disable iff (rst)
        strobe |=> (len_out >= 3'd1 && len_out <= 3'd4));

    // R9
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> ($stable(addr_out) && $stable(addr_ok) && $stable(len_out) && $stable(next_pc)));
endmodule

// File: tb/ea_gen_unit_tb.sv
module ea_gen_unit_tb_top;
    typedef struct packed {
        logic [1:0]  mode;
        logic [7:0]  b1;
        logic [7:0]  b2;
        logic        sel;
        logic [15:0] ix;
        logic [15:0] iy;
        logic [15:0] pc;
        logic        cond;
        logic        pre;
        logic [15:0] e_addr;
        logic        e_ok;
        logic [2:0]  e_len;
        logic [15:0] e_npc;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        // R1 R7 R8: extended, no prebyte
        '{2'b01, 8'h12, 8'h34, 1'b0, 16'h1000, 16'h2000, 16'h0100, 1'b0, 1'b0, 16'h1234, 1'b1, 3'd3, 16'h0103},
        // R1 R3 R7: extended with prebyte, pc wraps
        '{2'b01, 8'hFF, 8'hFE, 1'b0, 16'h1000, 16'h2000, 16'hFFFE, 1'b0, 1'b1, 16'hFFFE, 1'b1, 3'd4, 16'h0002},
        // R2 R8: indexed via IX
        '{2'b10, 8'h80, 8'h00, 1'b0, 16'h1000, 16'h2000, 16'h0200, 1'b0, 1'b0, 16'h1080, 1'b1, 3'd2, 16'h0202},
        // R2 R3 R7: indexed via IY, sum wraps, prebyte
        '{2'b10, 8'hFF, 8'h00, 1'b1, 16'h1000, 16'hFFF0, 16'h0300, 1'b0, 1'b1, 16'h00EF, 1'b1, 3'd3, 16'h0303},
        // R4 R7 R8: inherent
        '{2'b00, 8'h55, 8'hAA, 1'b0, 16'h1000, 16'h2000, 16'h0400, 1'b0, 1'b0, 16'h0000, 1'b0, 3'd1, 16'h0401},
        // R4 R3 R7: inherent with prebyte, pc wraps
        '{2'b00, 8'h00, 8'h00, 1'b0, 16'h1000, 16'h2000, 16'hFFFF, 1'b0, 1'b1, 16'h0000, 1'b0, 3'd2, 16'h0001},
        // R5: relative taken, forward
        '{2'b11, 8'h10, 8'h00, 1'b0, 16'h1000, 16'h2000, 16'h0500, 1'b1, 1'b0, 16'h0512, 1'b1, 3'd2, 16'h0512},
        // R5: relative taken, backward
        '{2'b11, 8'hF0, 8'h00, 1'b0, 16'h1000, 16'h2000, 16'h0500, 1'b1, 1'b0, 16'h04F2, 1'b1, 3'd2, 16'h04F2},
        // R6: relative not taken
        '{2'b11, 8'hF0, 8'h00, 1'b0, 16'h1000, 16'h2000, 16'h0500, 1'b0, 1'b0, 16'h04F2, 1'b1, 3'd2, 16'h0502},
        // R5 R3 R7: taken, -128, prebyte, wraps below zero
        '{2'b11, 8'h80, 8'h00, 1'b0, 16'h1000, 16'h2000, 16'h0010, 1'b1, 1'b1, 16'hFF93, 1'b1, 3'd3, 16'hFF93},
        // R5 R3: taken, +127, wraps above top
        '{2'b11, 8'h7F, 8'h00, 1'b0, 16'h1000, 16'h2000, 16'hFFF0, 1'b1, 1'b0, 16'h0071, 1'b1, 3'd2, 16'h0071},
        // R2: zero offset
        '{2'b10, 8'h00, 8'h00, 1'b0, 16'hABCD, 16'h2000, 16'h0000, 1'b0, 1'b0, 16'hABCD, 1'b1, 3'd2, 16'h0002}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strobe = 1'b0;
    logic [1:0]  mode = '0;
    logic [7:0]  op_first = '0;
    logic [7:0]  op_second = '0;
    logic        idx_sel = 1'b0;
    logic [15:0] reg_ix = '0;
    logic [15:0] reg_iy = '0;
    logic [15:0] insn_pc = '0;
    logic        br_taken = 1'b0;
    logic        has_pre = 1'b0;
    logic [15:0] addr_out;
    logic        addr_ok;
    logic [2:0]  len_out;
    logic [15:0] next_pc;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ea_gen_unit dut_i (
        .clk(clk), .rst(rst), .strobe(strobe), .mode(mode),
        .op_first(op_first), .op_second(op_second), .idx_sel(idx_sel),
        .reg_ix(reg_ix), .reg_iy(reg_iy), .insn_pc(insn_pc),
        .br_taken(br_taken), .has_pre(has_pre),
        .addr_out(addr_out), .addr_ok(addr_ok), .len_out(len_out), .next_pc(next_pc)
    );

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(vec_t v, logic stb);
        @(negedge clk);
        mode = v.mode; op_first = v.b1; op_second = v.b2; idx_sel = v.sel;
        reg_ix = v.ix; reg_iy = v.iy; insn_pc = v.pc; br_taken = v.cond;
        has_pre = v.pre; strobe = stb;
        @(negedge clk);
        strobe = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        chk("R10 addr after reset", addr_out, 16'h0000);
        chk("R10 ok after reset", {15'd0, addr_ok}, 16'h0000);
        chk("R10 len after reset", {13'd0, len_out}, 16'h0000);
        chk("R10 npc after reset", next_pc, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i], 1'b1);
            chk($sformatf("vec%0d addr (R1 R2 R4 R5)", i), addr_out, VECS[i].e_addr);
            chk($sformatf("vec%0d ok (R1 R2 R4)", i), {15'd0, addr_ok}, {15'd0, VECS[i].e_ok});
            chk($sformatf("vec%0d len (R7)", i), {13'd0, len_out}, {13'd0, VECS[i].e_len});
            chk($sformatf("vec%0d npc (R5 R6 R8 R3)", i), next_pc, VECS[i].e_npc);
        end

        // R9: without strobe new inputs are ignored; outputs keep the last vector
        apply(VECS[0], 1'b0);
        chk("R9 hold addr", addr_out, VECS[NV-1].e_addr);
        chk("R9 hold len", {13'd0, len_out}, {13'd0, VECS[NV-1].e_len});
        chk("R9 hold npc", next_pc, VECS[NV-1].e_npc);

        // R9: one-clock latency, outputs still old just before the capture edge
        @(negedge clk);
        mode = 2'b01; op_first = 8'hBE; op_second = 8'hEF; has_pre = 1'b0;
        insn_pc = 16'h0000; strobe = 1'b1;
        chk("R9 before capture edge", addr_out, VECS[NV-1].e_addr);
        @(negedge clk);
        strobe = 1'b0;
        chk("R9 after capture edge", addr_out, 16'hBEEF);

        // R10: reset clears loaded outputs
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R10 addr cleared", addr_out, 16'h0000);
        chk("R10 npc cleared", next_pc, 16'h0000);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule